// File: doc/BRIEF.md
# Two-Phase Bus Cycle Qualifier

This block monitors a processor local bus that is clocked by a double-rate input clock. It derives the bus phase by dividing that clock by two. It samples the three status lines only on a double-rate edge where the recovered phase is high and the active-low address strobe is low. Each such sample is classified as one of seven bus operations. The block reports the result as a single-cycle valid pulse with a one-hot type vector. A lock bit is added when the cycle is a memory read or memory write and the lock input is active.

The block also tracks whether a bus cycle is in progress. It answers another master's hold request with a hold acknowledge. The grant is given only when the bus is idle and no locked read-modify-write sequence is being held. While the grant is asserted, the bus belongs to the other master, so address strobes are not qualified.

Top module: `bus_cycle_qualifier`

## Requirements
- R1: After reset is released `phase_o` is 1. It inverts on every rising edge of `clk2_i`.
- R2: A qualifying edge is a rising edge of `clk2_i` where `phase_o` is 1, `ads_ni` is 0 and `hlda_o` is 0. If the status is legal, `valid_o` is 1 for exactly the one `clk2_i` cycle that follows that edge.
- R3: A status sampled with `ads_ni` high or with `phase_o` low produces no `valid_o`, `error_o` or `locked_o` and does not start a cycle.
- R4: `status_i` is {memory/IO, data/control, write/read}. While `valid_o` is 1, exactly one bit of `type_o` is set: bit 0 interrupt acknowledge (000), bit 1 I/O read (010), bit 2 I/O write (011), bit 3 instruction fetch (100), bit 4 halt/shutdown (101), bit 5 memory read (110), bit 6 memory write (111). `type_o` is 0 when `valid_o` is 0.
- R5: A qualifying edge with status 001 pulses `error_o` for one cycle. It leaves `valid_o` at 0 and does not start a cycle.
- R6: `locked_o` is 1 with `valid_o` only when the qualified type is memory read or memory write and `lock_i` was 1 at the qualifying edge.
- R7: `busy_o` rises with each `valid_o`. It clears after a phase-high edge where `cycle_end_i` is 1 and no new cycle is qualified.
- R8: `hlda_o` rises after a phase-high edge where `hold_i` is 1, `busy_o` is 0, `lock_i` is 0 and no strobe is qualified. It is never granted while a locked sequence holds `lock_i` high.
- R9: `hlda_o` falls after the first phase-high edge where `hold_i` is 0. It stays 1 while `hold_i` stays 1.
- R10: While `rst_ni` is low, all outputs are 0 except `phase_o`, which is 1.
- R11: While `hlda_o` is 1, address strobes are ignored: no `valid_o` or `error_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2_i | input | 1 | Double-rate bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ads_ni | input | 1 | Address strobe, active low |
| status_i | input | 3 | Bus status {memory/IO, data/control, write/read} |
| lock_i | input | 1 | Locked sequence active |
| cycle_end_i | input | 1 | Current bus cycle completes at this phase-high edge |
| hold_i | input | 1 | Bus request from another master |
| phase_o | output | 1 | Recovered bus phase |
| valid_o | output | 1 | One-cycle pulse for a qualified legal cycle |
| type_o | output | 7 | One-hot bus operation type |
| locked_o | output | 1 | Qualified cycle is a locked memory access |
| error_o | output | 1 | Qualified cycle carried the illegal status code |
| busy_o | output | 1 | Bus cycle in progress |
| hlda_o | output | 1 | Hold acknowledge |

## Verification
The bench drives strobes on phase-low edges. A design that ignored the phase would report cycles twice per bus clock, or on the wrong half. Locked memory cycles are made to overlap a pending hold request. A design that checked only the bus-idle condition would grant the bus inside a read-modify-write sequence. Other cases cover the illegal status 001, where a faulty design would report a valid type or stay busy. Strobes are also asserted during a grant, where a faulty design would emit cycles that belong to the other master. Hold is dropped during a phase-low half, and a faulty design would release on the wrong edge.

// File: rtl/bcq_pkg.sv
package bcq_pkg;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned N_OPS  = 7;

  typedef enum logic [2:0] {
    OP_INTA  = 3'd0,
    OP_IORD  = 3'd1,
    OP_IOWR  = 3'd2,
    OP_FETCH = 3'd3,
    OP_HALT  = 3'd4,
    OP_MRD   = 3'd5,
    OP_MWR   = 3'd6
  } op_e;

  localparam logic [STAT_W-1:0] ILLEGAL_CODE = 3'b001;

  // Status code that selects each operation, indexed by op_e
  function automatic logic [STAT_W-1:0] op_code(input int unsigned idx);
    case (idx)
      0:       op_code = 3'b000;
      1:       op_code = 3'b010;
      2:       op_code = 3'b011;
      3:       op_code = 3'b100;
      4:       op_code = 3'b101;
      5:       op_code = 3'b110;
      default: op_code = 3'b111;
    endcase
  endfunction

  function automatic logic is_mem_data(input logic [STAT_W-1:0] s);
    is_mem_data = (s[2:1] == 2'b11);
  endfunction
endpackage

// File: rtl/bcq_phase_gen.sv
module bcq_phase_gen (
  input  logic clk2_i,
  input  logic rst_ni,
  output logic phase_o
);
  logic phase_q;

  // Reset leaves phase high so the first edge after release is a sample edge
  always_ff @(posedge clk2_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b1;
    else         phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;

  p_phase_toggle_r1: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    1'b1 |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/bcq_status_decode.sv
module bcq_status_decode
  import bcq_pkg::*;
(
  input  logic              clk2_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              lock_i,
  output logic              start_o,
  output logic              valid_o,
  output logic [N_OPS-1:0]  type_o,
  output logic              locked_o,
  output logic              error_o
);
  logic             illegal;
  logic [N_OPS-1:0] hit;
  logic             valid_q, locked_q, error_q;
  logic [N_OPS-1:0] type_q;

  assign illegal = (status_i == ILLEGAL_CODE);
  assign start_o = sample_i && !illegal;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    assign hit[g] = (status_i == op_code(g));
    always_ff @(posedge clk2_i or negedge rst_ni) begin
      if (!rst_ni) type_q[g] <= 1'b0;
      else         type_q[g] <= start_o && hit[g];
    end
  end

  always_ff @(posedge clk2_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      locked_q <= 1'b0;
      error_q  <= 1'b0;
    end else begin
      valid_q  <= start_o;
      locked_q <= start_o && lock_i && is_mem_data(status_i);
      error_q  <= sample_i && illegal;
    end
  end

  assign valid_o  = valid_q;
  assign type_o   = type_q;
  assign locked_o = locked_q;
  assign error_o  = error_q;

  p_type_onehot_r4: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    valid_o |-> ($countones(type_o) == 1));
  p_type_idle_r4: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    !valid_o |-> (type_o == '0));
  p_valid_pulse_r2: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_error_excl_r5: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    error_o |-> !valid_o);
  p_locked_mem_r6: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    locked_o |-> (valid_o && (type_o[OP_MRD] || type_o[OP_MWR])));
endmodule

// File: rtl/bcq_hold_ctrl.sv
module bcq_hold_ctrl (
  input  logic clk2_i,
  input  logic rst_ni,
  input  logic phase_i,
  input  logic sample_i,
  input  logic start_i,
  input  logic cycle_end_i,
  input  logic hold_i,
  input  logic lock_i,
  output logic busy_o,
  output logic hlda_o
);
  logic busy_q, hlda_q, grant_ok;

  assign grant_ok = hold_i && !busy_q && !lock_i && !sample_i;

  always_ff @(posedge clk2_i or negedge rst_ni) begin
    if (!rst_ni)                       busy_q <= 1'b0;
    else if (start_i)                  busy_q <= 1'b1;
    else if (phase_i && cycle_end_i)   busy_q <= 1'b0;
  end

  always_ff @(posedge clk2_i or negedge rst_ni) begin
    if (!rst_ni) hlda_q <= 1'b0;
    else if (phase_i) begin
      if (hlda_q && !hold_i)       hlda_q <= 1'b0;
      else if (!hlda_q && grant_ok) hlda_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign hlda_o = hlda_q;

  p_grant_idle_r8: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(hold_i && !lock_i && !busy_o));
  p_grant_held_r9: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    (hlda_o && hold_i) |=> hlda_o);
  p_start_busy_r7: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/bus_cycle_qualifier.sv
module bus_cycle_qualifier
  import bcq_pkg::*;
(
  input  logic              clk2_i,
  input  logic              rst_ni,
  input  logic              ads_ni,
  input  logic [STAT_W-1:0] status_i,
  input  logic              lock_i,
  input  logic              cycle_end_i,
  input  logic              hold_i,
  output logic              phase_o,
  output logic              valid_o,
  output logic [N_OPS-1:0]  type_o,
  output logic              locked_o,
  output logic              error_o,
  output logic              busy_o,
  output logic              hlda_o
);
  logic sample, start;

  bcq_phase_gen i_phase (
    .clk2_i (clk2_i),
    .rst_ni (rst_ni),
    .phase_o(phase_o)
  );

  // Strobe is only meaningful in the high phase and while this side owns the bus
  assign sample = phase_o && !ads_ni && !hlda_o;

  bcq_status_decode i_dec (
    .clk2_i  (clk2_i),
    .rst_ni  (rst_ni),
    .sample_i(sample),
    .status_i(status_i),
    .lock_i  (lock_i),
    .start_o (start),
    .valid_o (valid_o),
    .type_o  (type_o),
    .locked_o(locked_o),
    .error_o (error_o)
  );

  bcq_hold_ctrl i_hold (
    .clk2_i     (clk2_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase_o),
    .sample_i   (sample),
    .start_i    (start),
    .cycle_end_i(cycle_end_i),
    .hold_i     (hold_i),
    .lock_i     (lock_i),
    .busy_o     (busy_o),
    .hlda_o     (hlda_o)
  );

  p_valid_phase_r2: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    (valid_o || error_o) |-> !phase_o);
  p_strobe_high_ignored_r3: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    ads_ni |=> (!valid_o && !error_o && !locked_o));
  p_granted_ignored_r11: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    hlda_o |=> (!valid_o && !error_o));
endmodule

// File: tb/test_bus_cycle_qualifier.sv
`timescale 1ns/1ps
module test_bus_cycle_qualifier;
  logic       clk2 = 1'b0;
  logic       rst_n = 1'b0;
  logic       ads_n = 1'b1;
  logic [2:0] status = 3'b000;
  logic       lock = 1'b0, cyc_end = 1'b0, hold = 1'b0;
  logic       phase, valid, locked, error, busy, hlda;
  logic [6:0] typ;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state from the requirements
  logic m_phase, m_busy, m_hlda;

  bus_cycle_qualifier i_bus_cycle_qualifier (
    .clk2_i(clk2), .rst_ni(rst_n), .ads_ni(ads_n), .status_i(status),
    .lock_i(lock), .cycle_end_i(cyc_end), .hold_i(hold),
    .phase_o(phase), .valid_o(valid), .type_o(typ), .locked_o(locked),
    .error_o(error), .busy_o(busy), .hlda_o(hlda)
  );

  always #2 clk2 = ~clk2;

  function automatic logic [6:0] exp_type(input logic [2:0] s);
    case (s)
      3'b000: return 7'b0000001;
      3'b010: return 7'b0000010;
      3'b011: return 7'b0000100;
      3'b100: return 7'b0001000;
      3'b101: return 7'b0010000;
      3'b110: return 7'b0100000;
      3'b111: return 7'b1000000;
      default: return 7'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One rising edge: advance the model, then compare all outputs
  task automatic tick();
    logic q, e_valid, e_err, e_lock;
    logic [6:0] e_type;
    @(posedge clk2);
    q       = m_phase && !ads_n && !m_hlda;
    e_valid = q && (status != 3'b001);
    e_err   = q && (status == 3'b001);
    e_type  = e_valid ? exp_type(status) : 7'b0;
    e_lock  = e_valid && lock && (status[2:1] == 2'b11);
    if (m_phase) begin
      if (m_hlda && !hold) m_hlda = 1'b0;
      else if (!m_hlda && hold && !m_busy && !lock && !q) m_hlda = 1'b1;
    end
    if (e_valid) m_busy = 1'b1;
    else if (m_phase && cyc_end) m_busy = 1'b0;
    m_phase = !m_phase;
    #1;
    chk("R1 phase", phase, m_phase);
    chk("R2/R3/R11 valid", valid, e_valid);
    chk("R4 type", typ, e_type);
    chk("R5 error", error, e_err);
    chk("R6 locked", locked, e_lock);
    chk("R7 busy", busy, m_busy);
    chk("R8/R9 hlda", hlda, m_hlda);
  endtask

  task automatic set_in(input logic a, input logic [2:0] s, input logic l,
                        input logic e, input logic h);
    ads_n = a; status = s; lock = l; cyc_end = e; hold = h;
  endtask

  initial begin
    repeat (100000) @(posedge clk2);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #9;
    chk("R10 reset phase", phase, 1'b1);
    chk("R10 reset outs", {valid, typ, locked, error, busy, hlda}, 12'h0);
    @(negedge clk2);
    rst_n = 1'b1;
    m_phase = 1'b1; m_busy = 1'b0; m_hlda = 1'b0;
    #1;
    // R2: strobe on the first (phase-high) edge, memory write
    set_in(1'b0, 3'b111, 1'b0, 1'b0, 1'b0); tick();
    // R3: strobe held on phase-low edge is ignored
    tick();
    set_in(1'b1, 3'b001, 1'b0, 1'b0, 1'b0); tick(); tick();
    // R5: illegal code at a phase-high edge
    set_in(1'b0, 3'b001, 1'b0, 1'b1, 1'b0); tick();
    set_in(1'b1, 3'b000, 1'b0, 1'b0, 1'b0); tick();
    // R4: every legal code once
    for (int c = 0; c < 8; c++) begin
      set_in(1'b0, 3'(c), 1'b0, 1'b1, 1'b0); tick();
      set_in(1'b1, 3'(c), 1'b0, 1'b1, 1'b0); tick();
    end
    // R6/R8: locked read-modify-write with hold pending, grant deferred
    set_in(1'b0, 3'b110, 1'b1, 1'b0, 1'b1); tick(); tick();
    set_in(1'b1, 3'b110, 1'b1, 1'b1, 1'b1); tick(); tick();
    set_in(1'b0, 3'b111, 1'b1, 1'b0, 1'b1); tick(); tick();
    set_in(1'b1, 3'b111, 1'b1, 1'b1, 1'b1); tick(); tick();
    chk("R8 no grant under lock", hlda, 1'b0);
    set_in(1'b1, 3'b111, 1'b0, 1'b0, 1'b1); tick(); tick();
    chk("R8 grant after lock", hlda, 1'b1);
    // R11: strobes during grant ignored
    set_in(1'b0, 3'b110, 1'b0, 1'b0, 1'b1); tick(); tick(); tick(); tick();
    // R9: hold dropped in phase-low half
    tick();
    set_in(1'b1, 3'b110, 1'b0, 1'b0, 1'b0); tick(); tick();
    chk("R9 released", hlda, 1'b0);
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      set_in(r[2:0] < 3'd5, r[5:3], (r[9:6] < 4'd5) ? !lock : lock,
             r[12:10] < 3'd3, (r[16:13] < 4'd3) ? !hold : hold);
      tick();
    end
    // R10: async reset mid-run
    @(negedge clk2);
    rst_n = 1'b0;
    #1;
    chk("R10 reset phase", phase, 1'b1);
    chk("R10 reset outs", {valid, typ, locked, error, busy, hlda}, 12'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule